// File: doc/BRIEF.md
# Framed Symbol Stream Length Checker

This block watches a byte-wide symbol stream in which every byte comes with a flag that marks it as a control character. A frame opens on a control-flagged start code and closes on a control-flagged end code. The block counts the plain data bytes inside each frame and checks that count against an expected frame size supplied on an input. A typical use is confirming that a fixed-size message, such as an interrupt message, left the transmit path whole: the checker taps the serial-side byte stream and reports each frame's length and verdict.

For every closed frame the block gives a one-cycle completion pulse, the measured length, and a one-cycle match or mismatch pulse. A running count of closed frames is kept. Out-of-order delimiters give a one-cycle framing-error pulse. The block does not decode frame contents, check CRCs or deskew lanes.

Top module: `frame_len_checker`

## Requirements
- R1: While reset is low, and in the first cycle after it, every output is zero: pkt_done, len_ok, len_bad, frame_err, meas_len and pkt_count.
- R2: A byte with sym_valid high, sym_is_ctrl high and value 0xFB opens a frame and sets the frame's byte count to zero.
- R3: A byte with sym_valid high, sym_is_ctrl high and value 0xFD closes an open frame. In the next cycle pkt_done is high for one cycle and meas_len holds the number of counted data bytes between the two delimiters.
- R4: A byte with sym_is_ctrl low counts as one data byte of an open frame whatever its value, 0xFB and 0xFD included. It never opens or closes a frame.
- R5: A cycle with sym_valid low has no effect. A control-flagged byte other than the two delimiter codes is not counted and has no effect. Data bytes outside an open frame are not counted and have no effect.
- R6: In the cycle pkt_done is high, exactly one of len_ok and len_bad is high: len_ok when meas_len equals the exp_len value present on the closing byte's cycle, len_bad otherwise. Both are low in every other cycle.
- R7: A start code that arrives while a frame is open gives a one-cycle frame_err pulse in the next cycle. The frame stays open and its count restarts from zero.
- R8: An end code that arrives with no open frame gives a one-cycle frame_err pulse in the next cycle. It leaves pkt_done low and meas_len and pkt_count unchanged.
- R9: pkt_count rises by one in each cycle that pkt_done is high, wraps modulo 2^CNT_W, and holds at all other times.
- R10: The byte count of a frame saturates at 2^LEN_W-1 and does not wrap.
- R11: meas_len holds its last value in every cycle in which pkt_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | The byte on sym_data is sampled in this cycle |
| sym_is_ctrl | input | 1 | The byte is a control character |
| sym_data | input | SYM_W | Stream byte |
| exp_len | input | LEN_W | Expected data-byte count of a frame |
| pkt_done | output | 1 | One-cycle pulse: a frame closed |
| meas_len | output | LEN_W | Data-byte count of the last closed frame |
| len_ok | output | 1 | One-cycle pulse: count matched exp_len |
| len_bad | output | 1 | One-cycle pulse: count differed from exp_len |
| frame_err | output | 1 | One-cycle pulse: delimiter out of order |
| pkt_count | output | CNT_W | Number of closed frames, wrapping |

## Verification
The hardest cases to reach from the ports are the saturated byte count and the wrap of the frame counter. Each needs a long run of traffic before the state exists at all. The bench reaches them by feeding one frame of 300 data bytes with an 8-bit count, and then more than 256 frames in total across a sweep of every length from 0 to 63 followed by a run of empty frames. Frame bodies mix in delimiter values with the control flag clear, stalled cycles that carry an end code, and foreign control characters, so the expected length computed in the bench shows any of these that leaks into the count.

// File: rtl/flc_pkg.sv
package flc_pkg;

    // Classification of one sampled stream byte.
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,   // not sampled, or a foreign control character
        KIND_DATA = 2'd1,   // ordinary payload byte
        KIND_SOF  = 2'd2,   // frame opener
        KIND_EOF  = 2'd3    // frame closer
    } sym_kind_e;

    localparam logic [7:0] SOF_BYTE = 8'hFB;
    localparam logic [7:0] EOF_BYTE = 8'hFD;

endpackage

// File: rtl/flc_sym_classify.sv
module flc_sym_classify
    import flc_pkg::*;
#(
    parameter int              SYM_W    = 8,
    parameter logic [SYM_W-1:0] SOF_CODE = SYM_W'(SOF_BYTE),
    parameter logic [SYM_W-1:0] EOF_CODE = SYM_W'(EOF_BYTE)
) (
    input  logic             valid,
    input  logic             is_ctrl,
    input  logic [SYM_W-1:0] data,
    output sym_kind_e        kind
);

    always_comb begin
        kind = KIND_NONE;
        if (valid) begin
            if (!is_ctrl) begin
                kind = KIND_DATA;
            end else if (data == SOF_CODE) begin
                kind = KIND_SOF;
            end else if (data == EOF_CODE) begin
                kind = KIND_EOF;
            end
        end
    end

endmodule

// File: rtl/flc_len_track.sv
module flc_len_track
    import flc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sym_kind_e        kind,
    output logic             end_hit,
    output logic             err_hit,
    output logic [LEN_W-1:0] final_len
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic             open;
        logic [LEN_W-1:0] count;
    } track_s;

    track_s track_d, track_q;

    always_comb begin
        track_d   = track_q;
        end_hit   = 1'b0;
        err_hit   = 1'b0;
        final_len = track_q.count;
        case (kind)
            KIND_SOF: begin
                err_hit       = track_q.open;
                track_d.open  = 1'b1;
                track_d.count = '0;
            end
            KIND_DATA: begin
                if (track_q.open && (track_q.count != LEN_MAX)) begin
                    track_d.count = track_q.count + 1'b1;
                end
            end
            KIND_EOF: begin
                if (track_q.open) begin
                    end_hit      = 1'b1;
                    track_d.open = 1'b0;
                end else begin
                    err_hit = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track_q <= '0;
        end else begin
            track_q <= track_d;
        end
    end

endmodule

// File: rtl/frame_len_checker.sv
module frame_len_checker
    import flc_pkg::*;
#(
    parameter int               SYM_W    = 8,
    parameter int               LEN_W    = 8,
    parameter int               CNT_W    = 8,
    parameter logic [SYM_W-1:0] SOF_CODE = SYM_W'(SOF_BYTE),
    parameter logic [SYM_W-1:0] EOF_CODE = SYM_W'(EOF_BYTE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             sym_is_ctrl,
    input  logic [SYM_W-1:0] sym_data,
    input  logic [LEN_W-1:0] exp_len,
    output logic             pkt_done,
    output logic [LEN_W-1:0] meas_len,
    output logic             len_ok,
    output logic             len_bad,
    output logic             frame_err,
    output logic [CNT_W-1:0] pkt_count
);

    typedef struct packed {
        logic             done;
        logic [LEN_W-1:0] len;
        logic             ok;
        logic             bad;
        logic             err;
        logic [CNT_W-1:0] pkts;
    } result_s;

    sym_kind_e        kind;
    logic             end_hit;
    logic             err_hit;
    logic [LEN_W-1:0] final_len;
    result_s          res_d, res_q;

    flc_sym_classify #(
        .SYM_W   (SYM_W),
        .SOF_CODE(SOF_CODE),
        .EOF_CODE(EOF_CODE)
    ) i_classify (
        .valid  (sym_valid),
        .is_ctrl(sym_is_ctrl),
        .data   (sym_data),
        .kind   (kind)
    );

    flc_len_track #(
        .LEN_W(LEN_W)
    ) i_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .end_hit  (end_hit),
        .err_hit  (err_hit),
        .final_len(final_len)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = end_hit;
        res_d.ok   = end_hit && (final_len == exp_len);
        res_d.bad  = end_hit && (final_len != exp_len);
        res_d.err  = err_hit;
        if (end_hit) begin
            res_d.len  = final_len;
            res_d.pkts = res_q.pkts + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign pkt_done  = res_q.done;
    assign meas_len  = res_q.len;
    assign len_ok    = res_q.ok;
    assign len_bad   = res_q.bad;
    assign frame_err = res_q.err;
    assign pkt_count = res_q.pkts;

endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
    parameter int               SYM_W    = 8,
    parameter int               LEN_W    = 8,
    parameter int               CNT_W    = 8,
    parameter logic [SYM_W-1:0] EOF_CODE = 8'hFD
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             sym_is_ctrl,
    input logic [SYM_W-1:0] sym_data,
    input logic [LEN_W-1:0] exp_len,
    input logic             pkt_done,
    input logic [LEN_W-1:0] meas_len,
    input logic             len_ok,
    input logic             len_bad,
    input logic             frame_err,
    input logic [CNT_W-1:0] pkt_count
);

    assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!pkt_done && !frame_err));

    assert_plain_byte_no_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_is_ctrl) |=> !pkt_done);

    assert_close_needs_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_is_ctrl && (sym_data != EOF_CODE)) |=> !pkt_done);

    assert_verdict_one_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (len_ok != len_bad));

    assert_verdict_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> (!len_ok && !len_bad));

    assert_verdict_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (len_ok == (meas_len == $past(exp_len))));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_count == CNT_W'($past(pkt_count) + 1'b1)));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> $stable(pkt_count));

    assert_len_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |-> $stable(meas_len));

endmodule

bind frame_len_checker flc_checker #(
    .SYM_W   (SYM_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .EOF_CODE(EOF_CODE)
) i_flc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_is_ctrl(sym_is_ctrl),
    .sym_data   (sym_data),
    .exp_len    (exp_len),
    .pkt_done   (pkt_done),
    .meas_len   (meas_len),
    .len_ok     (len_ok),
    .len_bad    (len_bad),
    .frame_err  (frame_err),
    .pkt_count  (pkt_count)
);

// File: tb/test_frame_len_checker.sv
module test_frame_len_checker;

    localparam int CLK_PERIOD = 10;
    localparam int SYM_W      = 8;
    localparam int LEN_W      = 8;
    localparam int CNT_W      = 8;
    localparam int LEN_CAP    = (1 << LEN_W) - 1;
    localparam int CNT_MOD    = 1 << CNT_W;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sym_valid;
    logic             sym_is_ctrl;
    logic [SYM_W-1:0] sym_data;
    logic [LEN_W-1:0] exp_len;
    logic             pkt_done;
    logic [LEN_W-1:0] meas_len;
    logic             len_ok;
    logic             len_bad;
    logic             frame_err;
    logic [CNT_W-1:0] pkt_count;

    int vectors   = 0;
    int misses    = 0;
    int exp_pkts  = 0;
    int last_len  = 0;
    int cycles    = 0;
    bit finished  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_len_checker #(
        .SYM_W(SYM_W),
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
    ) i_frame_len_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .sym_is_ctrl(sym_is_ctrl),
        .sym_data   (sym_data),
        .exp_len    (exp_len),
        .pkt_done   (pkt_done),
        .meas_len   (meas_len),
        .len_ok     (len_ok),
        .len_bad    (len_bad),
        .frame_err  (frame_err),
        .pkt_count  (pkt_count)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one byte at the falling edge; the next rising edge samples it.
    task automatic put(logic v, logic c, logic [7:0] d);
        @(negedge clk);
        sym_valid   = v;
        sym_is_ctrl = c;
        sym_data    = d;
    endtask

    // Frame body of n counted bytes, interleaved with bytes that must not count.
    task automatic body(int n);
        for (int i = 0; i < n; i++) begin
            if (i % 7 == 3) put(1'b0, 1'b1, 8'hFD);   // stalled cycle carrying an end code (R5)
            if (i % 11 == 5) put(1'b1, 1'b1, 8'hBC);  // foreign control character (R5)
            if (i % 4 == 1)      put(1'b1, 1'b0, 8'hFB); // start value as data (R4)
            else if (i % 4 == 2) put(1'b1, 1'b0, 8'hFD); // end value as data (R4)
            else                 put(1'b1, 1'b0, 8'(i));
        end
    endtask

    task automatic close_and_check(int n, int expl);
        int m;
        m = (n > LEN_CAP) ? LEN_CAP : n;
        put(1'b1, 1'b1, 8'hFD);
        put(1'b0, 1'b0, 8'h00);
        exp_pkts = (exp_pkts + 1) % CNT_MOD;
        check("R3 pkt_done pulse", int'(pkt_done), 1);
        check("R4/R5/R10 meas_len", int'(meas_len), m);
        check("R6 len_ok", int'(len_ok), (m == expl) ? 1 : 0);
        check("R6 len_bad", int'(len_bad), (m != expl) ? 1 : 0);
        check("R9 pkt_count step", int'(pkt_count), exp_pkts);
        check("R3 no frame_err", int'(frame_err), 0);
        put(1'b0, 1'b0, 8'h00);
        check("R3 pkt_done one cycle", int'(pkt_done), 0);
        check("R6 verdict one cycle", int'(len_ok | len_bad), 0);
        check("R11 meas_len held", int'(meas_len), m);
        last_len = m;
    endtask

    initial begin
        rst_n       = 1'b0;
        sym_valid   = 1'b0;
        sym_is_ctrl = 1'b0;
        sym_data    = '0;
        exp_len     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pkt_done reset", int'(pkt_done), 0);
        check("R1 meas_len reset", int'(meas_len), 0);
        check("R1 verdict reset", int'(len_ok | len_bad), 0);
        check("R1 frame_err reset", int'(frame_err), 0);
        check("R1 pkt_count reset", int'(pkt_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle quiet", int'(pkt_done | frame_err), 0);

        // Sweep every length 0..63 with matching and off-by-one expectations (R2, R3, R6).
        for (int n = 0; n < 64; n++) begin
            int expl;
            expl = (n % 3 == 0) ? n : ((n % 3 == 1) ? n + 1 : (n - 1) & LEN_CAP);
            exp_len = 8'(expl);
            if (n % 5 == 0) begin
                put(1'b1, 1'b0, 8'h55);  // data outside a frame (R5)
                put(1'b1, 1'b0, 8'hFD);
            end
            put(1'b1, 1'b1, 8'hFB);      // R2 opener
            body(n);
            close_and_check(n, expl);
        end

        // Stray closer with no open frame (R8).
        put(1'b1, 1'b1, 8'hFD);
        put(1'b0, 1'b0, 8'h00);
        check("R8 frame_err on stray closer", int'(frame_err), 1);
        check("R8 no pkt_done", int'(pkt_done), 0);
        check("R8 pkt_count unchanged", int'(pkt_count), exp_pkts);
        check("R8 meas_len unchanged", int'(meas_len), last_len);
        put(1'b0, 1'b0, 8'h00);
        check("R8 frame_err one cycle", int'(frame_err), 0);

        // Opener inside an open frame restarts the count (R7).
        exp_len = 8'd5;
        put(1'b1, 1'b1, 8'hFB);
        body(3);
        put(1'b1, 1'b1, 8'hFB);
        put(1'b1, 1'b0, 8'h11);
        check("R7 frame_err on nested opener", int'(frame_err), 1);
        check("R7 no pkt_done", int'(pkt_done), 0);
        body(4);
        close_and_check(5, 5);

        // Count saturation (R10).
        exp_len = 8'(LEN_CAP);
        put(1'b1, 1'b1, 8'hFB);
        body(300);
        close_and_check(300, LEN_CAP);

        // Empty frames until the frame counter wraps (R9).
        exp_len = 8'd0;
        for (int k = 0; k < 200; k++) begin
            put(1'b1, 1'b1, 8'hFB);
            close_and_check(0, 0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule